// File: doc/BRIEF.md
# Random-Seed Instruction Decoder

This block takes an instruction byte stream, one byte per accepted handshake, and recognises the single instruction that fetches a hardware entropy seed into a general register. It tracks the prefix bytes, matches the two-byte escape opcode and checks the ModRM byte. From the processor mode and the prefixes it works out the operand width (16, 32 or 64 bits) and the destination register index. The result is either one decoded micro-op or one undefined-opcode fault, shown for exactly one cycle after the byte that ends the decode.

The controller has four states. PREFIX collects optional prefix bytes and waits for the escape byte. ESCAPE waits for the second opcode byte. MODRM evaluates the final byte. REPORT shows the result for one cycle while the input is stalled. The transitions are as follows. PREFIX stays in PREFIX on a recognised prefix. PREFIX moves to ESCAPE on 0x0F. ESCAPE moves to MODRM on 0xC7. MODRM always moves to REPORT. REPORT always moves back to PREFIX. From PREFIX or ESCAPE, any unexpected byte, or a byte that reaches the length limit, moves to REPORT carrying a fault.

Top module: `rsd_decoder`

## Requirements
- R1: The sequence 0x0F, 0xC7, ModRM, where ModRM has mod=2'b11 and reg=3'b111, gives `uop_valid` high in the cycle after the edge that accepts the ModRM byte.
- R2: `uop_dst` is {REX.B, ModRM[2:0]}. REX.B is bit 0 of a 0x40-0x4F byte. It takes effect only in 64-bit mode, so registers 8 to 15 can be reached only there.
- R3: `uop_size` uses 2'b00 for 16 bits, 2'b01 for 32 bits and 2'b10 for 64 bits. REX.W (bit 3 of the REX byte) selects 64 bits. Without REX.W, a 0x66 prefix selects 16 bits. Otherwise the size is 32 bits, in both modes.
- R4: A REX byte counts only if it is the last prefix before 0x0F. A later 0x66 or 0xF0 cancels it, and a later REX byte replaces it.
- R5: Outside 64-bit mode, a byte in 0x40-0x4F in prefix position is not a prefix. It gives `fault_valid` in the cycle after it is accepted.
- R6: A 0xF0 prefix anywhere in the prefixes turns an otherwise valid decode into a fault.
- R7: While `feat_en` is 0, a completed decode reports a fault.
- R8: A ModRM byte with mod other than 2'b11, or with reg other than 3'b111, reports a fault.
- R9: In PREFIX, a byte that is not 0x66, 0xF0, 0x0F or a REX byte in 64-bit mode faults after it is accepted. In ESCAPE, any byte other than 0xC7 does the same.
- R10: If byte number MAX_BYTES (default 15) is accepted and is not the ModRM byte, it faults. An instruction of exactly MAX_BYTES bytes decodes normally.
- R11: `uop_valid` and `fault_valid` are never high together and each lasts one cycle. `in_ready` is low exactly in that cycle. `uop_size` and `uop_dst` are zero whenever `uop_valid` is low.
- R12: After reset `in_ready` is high and both result outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| long_mode | input | 1 | Core is in 64-bit mode |
| feat_en | input | 1 | Instruction enabled by the feature bit |
| in_valid | input | 1 | Instruction byte is present |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder accepts a byte this cycle |
| uop_valid | output | 1 | Decoded micro-op is present (one cycle) |
| uop_size | output | 2 | Operand width code |
| uop_dst | output | 4 | Destination register index |
| fault_valid | output | 1 | Undefined-opcode fault (one cycle) |

## Verification
On every cycle the assertions check several things. The two result strobes never overlap and each lasts one cycle. The stall lines up with the report cycle. Outputs are zero while idle. A result appears only after an accepted byte. A 64-bit width or an upper register appears only in 64-bit mode. A micro-op appears only while the feature is enabled. Other behaviour depends on the whole byte sequence, and only the bench scenarios can show it. This covers which prefix order honours or drops REX, the width priority between REX.W and 0x66, lock and ModRM faults, wrong second bytes and the exact length boundary. The bench sweeps modes, prefixes and ModRM values to cover these.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    typedef enum logic [1:0] {
        SZ16 = 2'b00,
        SZ32 = 2'b01,
        SZ64 = 2'b10
    } opsz_e;

    typedef enum logic [1:0] {
        ST_PREFIX = 2'd0,
        ST_ESCAPE = 2'd1,
        ST_MODRM  = 2'd2,
        ST_REPORT = 2'd3
    } dec_state_e;

    typedef struct packed {
        logic lock;
        logic osz;
        logic rex_v;
        logic rex_w;
        logic rex_b;
    } pfx_t;

    localparam logic [7:0] BYTE_ESC  = 8'h0F;
    localparam logic [7:0] BYTE_OP2  = 8'hC7;
    localparam logic [7:0] BYTE_LOCK = 8'hF0;
    localparam logic [7:0] BYTE_OSZ  = 8'h66;
    localparam logic [3:0] REX_HI    = 4'h4;
    localparam logic [2:0] REG_SEL   = 3'd7;
    localparam logic [1:0] MOD_REG   = 2'b11;

endpackage

// File: rtl/rsd_byte_class.sv
module rsd_byte_class
    import rsd_pkg::*;
(
    input  logic [7:0] byte_in,
    input  logic       long_mode,
    output logic       is_lock,
    output logic       is_osz,
    output logic       is_rex,
    output logic       is_esc
);
    always_comb begin
        is_lock = (byte_in == BYTE_LOCK);
        is_osz  = (byte_in == BYTE_OSZ);
        is_rex  = long_mode && (byte_in[7:4] == REX_HI);
        is_esc  = (byte_in == BYTE_ESC);
    end
endmodule

// File: rtl/rsd_pfx_track.sv
module rsd_pfx_track
    import rsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic is_lock,
    input  logic is_osz,
    input  logic is_rex,
    input  logic rex_w,
    input  logic rex_b,
    output pfx_t pfx
);
    pfx_t pfx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pfx_q <= '0;
        end else if (clr) begin
            pfx_q <= '0;
        end else if (load) begin
            if (is_lock) begin
                pfx_q.lock  <= 1'b1;
                pfx_q.rex_v <= 1'b0;
            end else if (is_osz) begin
                pfx_q.osz   <= 1'b1;
                pfx_q.rex_v <= 1'b0;
            end else if (is_rex) begin
                pfx_q.rex_v <= 1'b1;
                pfx_q.rex_w <= rex_w;
                pfx_q.rex_b <= rex_b;
            end
        end
    end

    assign pfx = pfx_q;
endmodule

// File: rtl/rsd_modrm_eval.sv
module rsd_modrm_eval
    import rsd_pkg::*;
(
    input  logic [7:0] modrm,
    input  pfx_t       pfx,
    input  logic       feat_en,
    output logic       bad,
    output opsz_e      size,
    output logic [3:0] dst
);
    logic [1:0] md;
    logic [2:0] rg;
    logic [2:0] rm;

    always_comb begin
        md  = modrm[7:6];
        rg  = modrm[5:3];
        rm  = modrm[2:0];
        bad = pfx.lock || !feat_en || (md != MOD_REG) || (rg != REG_SEL);
        if (pfx.rex_v && pfx.rex_w) begin
            size = SZ64;
        end else if (pfx.osz) begin
            size = SZ16;
        end else begin
            size = SZ32;
        end
        dst = {pfx.rex_v & pfx.rex_b, rm};
    end
endmodule

// File: rtl/rsd_len_ctr.sv
module rsd_len_ctr #(
    parameter int MAX_BYTES = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_BYTES + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(MAX_BYTES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != LAST_IDX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_limit = (cnt_q == LAST_IDX);
endmodule

// File: rtl/rsd_decoder.sv
module rsd_decoder
    import rsd_pkg::*;
#(
    parameter int MAX_BYTES = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       long_mode,
    input  logic       feat_en,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       uop_valid,
    output logic [1:0] uop_size,
    output logic [3:0] uop_dst,
    output logic       fault_valid
);
    localparam int DST_W = 4;

    dec_state_e state_q, state_d;
    logic       acc;
    logic       is_lock, is_osz, is_rex, is_esc;
    logic       at_limit;
    logic       pfx_load;
    pfx_t       pfx;
    logic       ev_bad;
    opsz_e      ev_size;
    logic [DST_W-1:0] ev_dst;

    logic       fin;
    logic       fin_fault;
    logic       res_fault_q;
    opsz_e      res_size_q;
    logic [DST_W-1:0] res_dst_q;

    assign in_ready = (state_q != ST_REPORT);
    assign acc      = in_valid && in_ready;

    rsd_byte_class u_class (
        .byte_in   (in_data),
        .long_mode (long_mode),
        .is_lock   (is_lock),
        .is_osz    (is_osz),
        .is_rex    (is_rex),
        .is_esc    (is_esc)
    );

    rsd_pfx_track u_pfx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == ST_REPORT),
        .load    (pfx_load),
        .is_lock (is_lock),
        .is_osz  (is_osz),
        .is_rex  (is_rex),
        .rex_w   (in_data[3]),
        .rex_b   (in_data[0]),
        .pfx     (pfx)
    );

    rsd_len_ctr #(.MAX_BYTES(MAX_BYTES)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_q == ST_REPORT),
        .inc      (acc),
        .at_limit (at_limit)
    );

    rsd_modrm_eval u_eval (
        .modrm   (in_data),
        .pfx     (pfx),
        .feat_en (feat_en),
        .bad     (ev_bad),
        .size    (ev_size),
        .dst     (ev_dst)
    );

    // Next state and completion decode
    always_comb begin
        state_d   = state_q;
        fin       = 1'b0;
        fin_fault = 1'b0;
        pfx_load  = 1'b0;
        unique case (state_q)
            ST_PREFIX: begin
                if (acc) begin
                    if (is_esc && !at_limit) begin
                        state_d = ST_ESCAPE;
                    end else if ((is_lock || is_osz || is_rex) && !at_limit) begin
                        pfx_load = 1'b1;
                    end else begin
                        fin       = 1'b1;
                        fin_fault = 1'b1;
                        state_d   = ST_REPORT;
                    end
                end
            end
            ST_ESCAPE: begin
                if (acc) begin
                    if ((in_data == BYTE_OP2) && !at_limit) begin
                        state_d = ST_MODRM;
                    end else begin
                        fin       = 1'b1;
                        fin_fault = 1'b1;
                        state_d   = ST_REPORT;
                    end
                end
            end
            ST_MODRM: begin
                if (acc) begin
                    fin       = 1'b1;
                    fin_fault = ev_bad;
                    state_d   = ST_REPORT;
                end
            end
            ST_REPORT: begin
                state_d = ST_PREFIX;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PREFIX;
        end else begin
            state_q <= state_d;
        end
    end

    // Result holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_fault_q <= 1'b0;
            res_size_q  <= SZ16;
            res_dst_q   <= '0;
        end else if (fin) begin
            res_fault_q <= fin_fault;
            res_size_q  <= fin_fault ? SZ16 : ev_size;
            res_dst_q   <= fin_fault ? '0 : ev_dst;
        end
    end

    // Outputs
    always_comb begin
        uop_valid   = (state_q == ST_REPORT) && !res_fault_q;
        fault_valid = (state_q == ST_REPORT) && res_fault_q;
        uop_size    = uop_valid ? res_size_q : 2'b00;
        uop_dst     = uop_valid ? res_dst_q  : '0;
    end
endmodule

// File: rtl/rsd_decoder_chk.sv
module rsd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       long_mode,
    input logic       feat_en,
    input logic       in_valid,
    input logic       in_ready,
    input logic       uop_valid,
    input logic [1:0] uop_size,
    input logic [3:0] uop_dst,
    input logic       fault_valid
);
    a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(uop_valid && fault_valid));

    a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid || fault_valid) |-> !in_ready);

    a_r11_stall_only: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (uop_valid || fault_valid));

    a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid || fault_valid) |=> !(uop_valid || fault_valid));

    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !uop_valid |-> (uop_size == 2'b00 && uop_dst == 4'd0));

    a_r1_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid || fault_valid) |-> $past(in_valid && in_ready));

    a_r3_code: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> (uop_size != 2'b11));

    a_r3_wide_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_size == 2'b10) |-> long_mode);

    a_r2_upper_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && uop_dst[3]) |-> long_mode);

    a_r7_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        uop_valid |-> $past(feat_en));
endmodule

bind rsd_decoder rsd_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .long_mode   (long_mode),
    .feat_en     (feat_en),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .uop_valid   (uop_valid),
    .uop_size    (uop_size),
    .uop_dst     (uop_dst),
    .fault_valid (fault_valid)
);

// File: tb/rsd_decoder_tb_top.sv
module rsd_decoder_tb_top;
    localparam int CLK_P     = 10;
    localparam int WATCHDOG  = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       long_mode = 1'b0;
    logic       feat_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       uop_valid;
    logic [1:0] uop_size;
    logic [3:0] uop_dst;
    logic       fault_valid;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    rsd_decoder dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .long_mode   (long_mode),
        .feat_en     (feat_en),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .uop_valid   (uop_valid),
        .uop_size    (uop_size),
        .uop_dst     (uop_dst),
        .fault_valid (fault_valid)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    // Result is due at the negedge after the accepting edge.
    task automatic expect_res(input bit ef, input logic [1:0] es, input logic [3:0] ed,
                              input string req);
        @(negedge clk);
        chk(fault_valid == ef && uop_valid == !ef, req,
            {30'd0, fault_valid, uop_valid}, {30'd0, ef, !ef});
        if (!ef) begin
            chk(uop_size == es, req, uop_size, es);
            chk(uop_dst == ed, req, uop_dst, ed);
        end
        chk(in_ready == 1'b0, "R11 stall", in_ready, 0);
        @(negedge clk);
        chk(!uop_valid && !fault_valid && in_ready, "R11 single pulse",
            {29'd0, uop_valid, fault_valid, in_ready}, 1);
    endtask

    initial begin
        logic [7:0] rex_tab [7];
        rex_tab[0] = 8'h40; rex_tab[1] = 8'h41; rex_tab[2] = 8'h48;
        rex_tab[3] = 8'h49; rex_tab[4] = 8'h4F; rex_tab[5] = 8'h46;
        rex_tab[6] = 8'h00;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready && !uop_valid && !fault_valid && uop_size == 0 && uop_dst == 0,
            "R12 reset", {29'd0, in_ready, uop_valid, fault_valid}, 4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !uop_valid && !fault_valid, "R12 after release",
            {29'd0, in_ready, uop_valid, fault_valid}, 4);

        // Sweep: mode, feature, lock, 0x66, REX choice, ModRM mod/reg/rm
        for (int lm = 0; lm < 2; lm++) begin
            for (int fe = 0; fe < 2; fe++) begin
                for (int lk = 0; lk < 2; lk++) begin
                    for (int p6 = 0; p6 < 2; p6++) begin
                        for (int rx = 0; rx < 7; rx++) begin
                            for (int mi = 0; mi < 32; mi++) begin
                                logic [7:0] mrm;
                                bit has_rex, ef;
                                logic [1:0] es;
                                logic [3:0] ed;
                                string req;
                                mrm = {(mi[4] ? 2'b11 : 2'b01), (mi[3] ? 3'd7 : 3'd6),
                                       mi[2:0]};
                                has_rex = (rx != 6);
                                long_mode = lm[0];
                                feat_en   = fe[0];
                                if (lk != 0) put(8'hF0);
                                if (p6 != 0) put(8'h66);
                                if (has_rex) put(rex_tab[rx]);
                                if (has_rex && lm == 0) begin
                                    expect_res(1'b1, 2'b00, 4'd0, "R5 REX outside 64-bit");
                                end else begin
                                    put(8'h0F);
                                    put(8'hC7);
                                    put(mrm);
                                    ef = (lk != 0) || (fe == 0) || !mi[4] || !mi[3];
                                    if (has_rex && rex_tab[rx][3]) es = 2'b10;
                                    else if (p6 != 0) es = 2'b00;
                                    else es = 2'b01;
                                    ed = {has_rex & rex_tab[rx][0], mrm[2:0]};
                                    if (fe == 0) req = "R7 feature off";
                                    else if (lk != 0) req = "R6 lock";
                                    else if (ef) req = "R8 ModRM form";
                                    else req = "R1/R2/R3 decode";
                                    expect_res(ef, es, ed, req);
                                end
                            end
                        end
                    end
                end
            end
        end

        long_mode = 1'b1;
        feat_en   = 1'b1;

        // R4: 0x66 after REX drops REX; later REX replaces earlier one
        put(8'h49); put(8'h66); put(8'h0F); put(8'hC7); put(8'hFB);
        expect_res(1'b0, 2'b00, 4'd3, "R4 REX cancelled by 0x66");
        put(8'h48); put(8'hF0); put(8'h0F); put(8'hC7); put(8'hF9);
        expect_res(1'b1, 2'b00, 4'd0, "R4/R6 lock after REX");
        put(8'h48); put(8'h41); put(8'h0F); put(8'hC7); put(8'hFA);
        expect_res(1'b0, 2'b01, 4'd10, "R4 last REX wins");

        // R9: bad first byte, bad second byte
        put(8'h90);
        expect_res(1'b1, 2'b00, 4'd0, "R9 unknown first byte");
        put(8'h0F); put(8'hC6);
        expect_res(1'b1, 2'b00, 4'd0, "R9 wrong second byte");
        put(8'h66); put(8'h0F); put(8'h0F);
        expect_res(1'b1, 2'b00, 4'd0, "R9 repeated escape");

        // R10: exactly 15 bytes decodes, 16 would fault at byte 15
        for (int i = 0; i < 12; i++) put(8'h66);
        put(8'h0F); put(8'hC7); put(8'hF8);
        expect_res(1'b0, 2'b00, 4'd0, "R10 length at limit");
        for (int i = 0; i < 13; i++) put(8'h66);
        put(8'h0F); put(8'hC7);
        expect_res(1'b1, 2'b00, 4'd0, "R10 length over limit");
        for (int i = 0; i < 15; i++) put(8'h66);
        expect_res(1'b1, 2'b00, 4'd0, "R10 prefix run at limit");

        // Decoder recovers after faults
        put(8'h4D); put(8'h0F); put(8'hC7); put(8'hFE);
        expect_res(1'b0, 2'b10, 4'd14, "R1/R2/R3 after recovery");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule